// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block keeps recently used page table entries next to the address translation logic, so a virtual page number can be turned into a physical page number without a memory access. Only the page number goes in; the page offset passes around the block untouched. The low bits of the page number pick a set. The remaining high bits are the tag, which is compared against every way of that set in parallel. A lookup is purely combinational and answers in the same cycle with a hit flag, the physical page number and the entry's present bit.

When a lookup misses, an external page table walker fetches the entry and writes it back through the refill port. A refill for a page number that is already held overwrites that line. Otherwise the refill takes the lowest-numbered empty way of the set. In a full set it evicts the way named by that set's round-robin pointer. A single flush input empties the whole buffer in one cycle.

There is no sequential control state. The only per-set state besides the lines is the round-robin victim pointer. Each refill is classified combinationally into one of four named kinds:
- FILL_NONE: no refill this cycle, or the refill is dropped because of a flush.
- FILL_UPDATE: the page number is already present and its line is rewritten.
- FILL_FREE: the refill goes into the lowest empty way.
- FILL_EVICT: the set is full, so the pointed-to way is replaced and the pointer steps by one.

Top module: `xlat_cache`

## Requirements
- R1: The set index is bits [3:0] of `lk_vpn` and the tag is bits [19:4]. `lk_hit` is 1 in the same cycle exactly when a valid line of that set holds that tag, and `lk_ppn`/`lk_present` then carry that line's stored values.
- R2: On a miss, `lk_ppn` is 0 and `lk_present` is 0.
- R3: After reset, no line is valid and every lookup misses.
- R4: A refill is written at the rising clock edge. A lookup of the same page number in the refill cycle still sees the old contents; from the next cycle on it hits with the refilled values.
- R5: A refill of a page number already held rewrites that line only. No second copy is made, the other ways of the set keep their entries, and the set's pointer does not move.
- R6: A refill of a new page number into a set with an empty way uses the lowest-numbered empty way and evicts nothing.
- R7: A refill of a new page number into a full set replaces the way given by that set's pointer, then advances the pointer by one, wrapping from the last way to way 0. Every pointer is 0 after reset.
- R8: `flush_all` clears every valid bit in one cycle. The round-robin pointers keep their values.
- R9: When `flush_all` and `fill_en` are both high in the same cycle, the flush wins and the refill is discarded.
- R10: The stored present bit is returned unchanged. A line refilled with present = 0 still hits (`lk_hit` = 1, `lk_present` = 0).
- R11: A refill only ever changes lines of its own set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | A valid matching line exists |
| lk_ppn | output | 20 | Physical page number of the hit, 0 on a miss |
| lk_present | output | 1 | Present bit of the hit, 0 on a miss |
| fill_en | input | 1 | Write one entry this cycle |
| fill_vpn | input | 20 | Page number of the entry to write |
| fill_ppn | input | 20 | Physical page number to store |
| fill_present | input | 1 | Present bit to store |
| flush_all | input | 1 | Invalidate every line this cycle |

## Verification
Two pairs of functions can land in the same cycle: a flush with a refill, and a lookup with a refill of the same page number.

For the first pair, the bench raises `flush_all` and `fill_en` together. It then looks up the refilled page number, which must miss, confirming that the flush took priority.

For the second pair, the bench presents the refill page number on the lookup port while the refill is pending. It expects a miss before the clock edge and a hit with the new physical page number after it.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

    // Classification of a refill request for the selected set
    typedef enum logic [1:0] {
        FILL_NONE   = 2'd0,
        FILL_UPDATE = 2'd1,
        FILL_FREE   = 2'd2,
        FILL_EVICT  = 2'd3
    } fill_kind_e;

endpackage

// File: rtl/xlat_way_match.sv
module xlat_way_match #(
    parameter int TAG_W = 16,
    parameter int WAYS  = 4
) (
    input  logic [WAYS-1:0]            line_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic [WAYS-1:0]            way_hit
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = line_valid[w] && (line_tag[w] == probe_tag);
    end

endmodule

// File: rtl/xlat_victim_pick.sv
module xlat_victim_pick
    import xlat_cache_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int IW  = $clog2(WAYS)
) (
    input  logic            req,
    input  logic [WAYS-1:0] line_valid,
    input  logic [WAYS-1:0] way_hit,
    input  logic [IW-1:0]   rr_ptr,
    output fill_kind_e      kind,
    output logic [IW-1:0]   way_sel
);

    logic          free_found;
    logic [IW-1:0] free_idx;
    logic [IW-1:0] hit_idx;

    // Lowest empty way and the index of the matching way
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        hit_idx    = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!line_valid[w]) begin
                free_found = 1'b1;
                free_idx   = w[IW-1:0];
            end
            if (way_hit[w]) begin
                hit_idx = w[IW-1:0];
            end
        end
    end

    // Refill classification
    always_comb begin
        if (!req)
            kind = FILL_NONE;
        else if (|way_hit)
            kind = FILL_UPDATE;
        else if (free_found)
            kind = FILL_FREE;
        else
            kind = FILL_EVICT;
    end

    // Target way for each kind
    always_comb begin
        unique case (kind)
            FILL_NONE:   way_sel = '0;
            FILL_UPDATE: way_sel = hit_idx;
            FILL_FREE:   way_sel = free_idx;
            FILL_EVICT:  way_sel = rr_ptr;
            default:     way_sel = '0;
        endcase
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_cache_pkg::*;
#(
    parameter int VPN_W    = 20,
    parameter int PPN_W    = 20,
    parameter int SET_BITS = 4,
    parameter int WAYS     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_present,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_present,
    input  logic             flush_all
);

    localparam int SETS  = 1 << SET_BITS;
    localparam int TAG_W = VPN_W - SET_BITS;
    localparam int IW    = $clog2(WAYS);

    // Line storage, one packed row of ways per set
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0][PPN_W-1:0] ppn_q   [SETS];
    logic [WAYS-1:0]            pres_q  [SETS];
    logic [IW-1:0]              rr_q    [SETS];

    // Lookup path
    logic [SET_BITS-1:0] lk_set;
    logic [TAG_W-1:0]    lk_tag;
    logic [WAYS-1:0]     lk_hit_vec;

    assign lk_set = lk_vpn[SET_BITS-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:SET_BITS];

    xlat_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_lk_match (
        .line_valid (valid_q[lk_set]),
        .line_tag   (tag_q[lk_set]),
        .probe_tag  (lk_tag),
        .way_hit    (lk_hit_vec)
    );

    always_comb begin
        lk_hit     = |lk_hit_vec;
        lk_ppn     = '0;
        lk_present = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_hit_vec[w]) begin
                lk_ppn     = lk_ppn | ppn_q[lk_set][w];
                lk_present = lk_present | pres_q[lk_set][w];
            end
        end
    end

    // Refill path
    logic [SET_BITS-1:0] fl_set;
    logic [TAG_W-1:0]    fl_tag;
    logic [WAYS-1:0]     fl_hit_vec;
    fill_kind_e          fl_kind;
    logic [IW-1:0]       fl_way;
    logic                fl_go;

    assign fl_set = fill_vpn[SET_BITS-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:SET_BITS];
    assign fl_go  = fill_en && !flush_all;

    xlat_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_fl_match (
        .line_valid (valid_q[fl_set]),
        .line_tag   (tag_q[fl_set]),
        .probe_tag  (fl_tag),
        .way_hit    (fl_hit_vec)
    );

    xlat_victim_pick #(.WAYS(WAYS)) u_pick (
        .req        (fl_go),
        .line_valid (valid_q[fl_set]),
        .way_hit    (fl_hit_vec),
        .rr_ptr     (rr_q[fl_set]),
        .kind       (fl_kind),
        .way_sel    (fl_way)
    );

    // Valid bits and victim pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                rr_q[s]    <= '0;
            end
        end else if (flush_all) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
            end
        end else if (fl_kind != FILL_NONE) begin
            valid_q[fl_set][fl_way] <= 1'b1;
            if (fl_kind == FILL_EVICT)
                rr_q[fl_set] <= rr_q[fl_set] + 1'b1;
        end
    end

    // Line payload, no reset needed
    always_ff @(posedge clk) begin
        if (fl_kind != FILL_NONE) begin
            tag_q[fl_set][fl_way]  <= fl_tag;
            ppn_q[fl_set][fl_way]  <= fill_ppn;
            pres_q[fl_set][fl_way] <= fill_present;
        end
    end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int WAYS  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_hit,
    input logic [PPN_W-1:0] lk_ppn,
    input logic             lk_present,
    input logic             fill_en,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [PPN_W-1:0] fill_ppn,
    input logic             fill_present,
    input logic             flush_all,
    input logic [WAYS-1:0]  way_hits
);

    // R3
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);

    // R2
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0 && !lk_present));

    // R4
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all) |=>
            ((lk_vpn != $past(fill_vpn)) ||
             (lk_hit && lk_ppn == $past(fill_ppn) && lk_present == $past(fill_present))));

    // R5
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hits));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !lk_hit);

endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .WAYS(WAYS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_vpn       (lk_vpn),
    .lk_hit       (lk_hit),
    .lk_ppn       (lk_ppn),
    .lk_present   (lk_present),
    .fill_en      (fill_en),
    .fill_vpn     (fill_vpn),
    .fill_ppn     (fill_ppn),
    .fill_present (fill_present),
    .flush_all    (flush_all),
    .way_hits     (lk_hit_vec)
);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic        lk_present;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_present = 1'b0;
    logic        flush_all = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xlat_cache i_xlat_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_present(lk_present),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_present(fill_present), .flush_all(flush_all)
    );

    function automatic logic [19:0] mk(input logic [15:0] tag, input logic [3:0] set);
        return {tag, set};
    endfunction

    // Compare the current lookup outputs (called away from the clock edge)
    task automatic cmp(input string req, input logic eh, input logic [19:0] ep, input logic epr);
        checks++;
        if (lk_hit !== eh || lk_ppn !== ep || lk_present !== epr) begin
            errors++;
            $display("FAIL %s vpn=%h actual hit=%b ppn=%h pres=%b expected hit=%b ppn=%h pres=%b",
                     req, lk_vpn, lk_hit, lk_ppn, lk_present, eh, ep, epr);
        end
    endtask

    task automatic look(input string req, input logic [19:0] vpn,
                        input logic eh, input logic [19:0] ep, input logic epr);
        @(negedge clk);
        lk_vpn = vpn;
        #1;
        cmp(req, eh, ep, epr);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic pres);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_present = pres;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
    endtask

    task automatic t_reset();
        look("R3", mk(16'h0000, 4'h0), 1'b0, 20'h0, 1'b0);
        look("R3", mk(16'h1234, 4'h3), 1'b0, 20'h0, 1'b0);
        look("R2", mk(16'hffff, 4'hf), 1'b0, 20'h0, 1'b0);
    endtask

    task automatic t_basic();
        fill(mk(16'h1234, 4'h3), 20'habcde, 1'b1);
        look("R1", mk(16'h1234, 4'h3), 1'b1, 20'habcde, 1'b1);
        look("R1", mk(16'h1235, 4'h3), 1'b0, 20'h0, 1'b0);
        look("R1", mk(16'h1234, 4'h4), 1'b0, 20'h0, 1'b0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = mk(16'h0777, 4'h7); fill_ppn = 20'h07070; fill_present = 1'b1;
        lk_vpn = mk(16'h0777, 4'h7);
        #1;
        cmp("R4 before edge", 1'b0, 20'h0, 1'b0);
        @(negedge clk);
        fill_en = 1'b0;
        #1;
        cmp("R4 after edge", 1'b1, 20'h07070, 1'b1);
    endtask

    task automatic t_order();
        for (int t = 1; t <= 4; t++)
            fill(mk(16'(t), 4'h5), 20'(16 + t), 1'b1);
        for (int t = 1; t <= 4; t++)
            look("R6", mk(16'(t), 4'h5), 1'b1, 20'(16 + t), 1'b1);
        fill(mk(16'd5, 4'h5), 20'd21, 1'b1);
        look("R7 way0 evicted", mk(16'd1, 4'h5), 1'b0, 20'h0, 1'b0);
        for (int t = 2; t <= 5; t++)
            look("R7", mk(16'(t), 4'h5), 1'b1, 20'(16 + t), 1'b1);
        fill(mk(16'd6, 4'h5), 20'd22, 1'b1);
        look("R7 way1 evicted", mk(16'd2, 4'h5), 1'b0, 20'h0, 1'b0);
        look("R7", mk(16'd6, 4'h5), 1'b1, 20'd22, 1'b1);
        look("R11", mk(16'h1234, 4'h3), 1'b1, 20'habcde, 1'b1);
        look("R11", mk(16'h0777, 4'h7), 1'b1, 20'h07070, 1'b1);
    endtask

    task automatic t_update();
        fill(mk(16'd4, 4'h5), 20'h00055, 1'b1);
        look("R5", mk(16'd4, 4'h5), 1'b1, 20'h00055, 1'b1);
        look("R5", mk(16'd3, 4'h5), 1'b1, 20'd19, 1'b1);
        look("R5", mk(16'd5, 4'h5), 1'b1, 20'd21, 1'b1);
        look("R5", mk(16'd6, 4'h5), 1'b1, 20'd22, 1'b1);
        fill(mk(16'd7, 4'h5), 20'd23, 1'b1);
        look("R7 way2 evicted", mk(16'd3, 4'h5), 1'b0, 20'h0, 1'b0);
        look("R5 pointer kept", mk(16'd4, 4'h5), 1'b1, 20'h00055, 1'b1);
        look("R7", mk(16'd7, 4'h5), 1'b1, 20'd23, 1'b1);
    endtask

    task automatic t_present();
        fill(mk(16'h0abc, 4'h9), 20'h00321, 1'b0);
        look("R10", mk(16'h0abc, 4'h9), 1'b1, 20'h00321, 1'b0);
    endtask

    task automatic t_flush();
        flush();
        look("R8", mk(16'h1234, 4'h3), 1'b0, 20'h0, 1'b0);
        look("R8", mk(16'd7, 4'h5), 1'b0, 20'h0, 1'b0);
        look("R8", mk(16'h0abc, 4'h9), 1'b0, 20'h0, 1'b0);
        for (int t = 8; t <= 11; t++)
            fill(mk(16'(t), 4'h5), 20'(t + 256), 1'b1);
        for (int t = 8; t <= 11; t++)
            look("R6 after flush", mk(16'(t), 4'h5), 1'b1, 20'(t + 256), 1'b1);
        fill(mk(16'd12, 4'h5), 20'd268, 1'b1);
        look("R8 pointer kept way3", mk(16'd11, 4'h5), 1'b0, 20'h0, 1'b0);
        look("R8 pointer kept", mk(16'd8, 4'h5), 1'b1, 20'd264, 1'b1);
    endtask

    task automatic t_collide();
        @(negedge clk);
        flush_all = 1'b1;
        fill_en = 1'b1; fill_vpn = mk(16'h0f0f, 4'h2); fill_ppn = 20'h0f0f0; fill_present = 1'b1;
        @(negedge clk);
        flush_all = 1'b0; fill_en = 1'b0;
        look("R9", mk(16'h0f0f, 4'h2), 1'b0, 20'h0, 1'b0);
        look("R9", mk(16'd8, 4'h5), 1'b0, 20'h0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_same_cycle();
        t_order();
        t_update();
        t_present();
        t_flush();
        t_collide();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all) actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule